// File: doc/BRIEF.md
# Event counter unit

A bank of event counters with a register port, for measuring activity in the blocks around it. Each counter has an event selector. The selector picks one lane of a wide event-increment vector. While the counter is running, it adds that lane's value every clock. A lane may carry more than one unit per cycle. Software loads and reads the counters, starts and stops them, and sets interrupt enables through the register port.

Counter enables and interrupt enables change only through separate set and clear registers. Overflow status is cleared by writing ones. Because of this, no software sequence needs a read-modify-write, and a driver can stop every counter or mask every interrupt with a single store of all ones.

The register port always accepts. It has no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where `wr_en` is high. Read data appears one cycle after the address is presented. A read has no side effects.

Top module: `evt_counter_unit`

## Requirements
- R1: After reset, every counter, selector, control field, enable mask and overflow bit reads zero, and `irq` is low.
- R2: Counter n sits at byte offset 0x000 + 8·n and can be read and written. A write overrides any increment due in the same cycle.
- R3: The selector at offset 0x200 + 8·n picks event lane `evt_inc[4·s +: 4]` using its low 8 bits `s`. While running, counter n adds that 4-bit value every cycle. A per-counter 8-bit control field at 0x100 + 8·n stores what is written and reads it back.
- R4: Bit 0 of the global control word at 0x400 is the master run bit and reads back. While it is 0, no counter changes except by a write.
- R5: Writing a 1 into bit 1 at 0x400 zeroes all counters at that edge. Overflow status is untouched, and the bit itself reads back as 0.
- R6: Each 1 in bits [7:0] written to 0x410 turns on the matching counter-run bit, and each 1 written to 0x418 turns it off. Zero bits leave their counter alone. Both offsets read the current run mask.
- R7: Offsets 0x420 (set) and 0x428 (clear) maintain the interrupt mask in the same way as R6, and both read it back.
- R8: When a counter carries out of its most significant bit, its bit in the status word at 0x440 is set. Writing a 1 to a status bit clears only that bit.
- R9: If a counter carries out in the same cycle that software clears its status bit, the bit ends up set.
- R10: `irq` is high exactly when some counter has both its status bit and its interrupt-mask bit set. It follows the registers with no extra delay.
- R11: Reading an unmapped offset, a counter index of 8 or more, or an address whose low three bits are not zero returns zero. Writes to such addresses change nothing. `rdata` shows the register state as it was at the edge that sampled `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 11 | Byte address of the register |
| wr_en | input | 1 | Write strobe for this cycle |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, registered, one cycle after `addr` |
| evt_inc | input | 1024 | 256 event lanes of 4 bits each, the increment per cycle |
| irq | output | 1 | Level interrupt: any overflow bit that is also interrupt-enabled |

## Verification
Two events can land on the same edge: a counter's carry-out setting its status bit, and a software write of ones to the status register. The bench causes this on purpose. It loads a counter just below all ones, and on the edge where the carry happens it writes the clear. The next status read must still show the bit. A second collision is a counter write against a running increment, where the written value must win. The random phase loads counters close to all ones while status clears are being written, so both collisions also happen without direction. Every result is compared with a cycle-accurate model in the bench.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  // register port geometry
  localparam int unsigned REG_AW = 11;
  localparam int unsigned IDX_W  = 5;
  // address regions, addr[10:8]
  localparam logic [2:0] RGN_CNT = 3'd0;
  localparam logic [2:0] RGN_CTL = 3'd1;
  localparam logic [2:0] RGN_SEL = 3'd2;
  localparam logic [2:0] RGN_GLB = 3'd4;
  // word slots inside the global region, addr[7:3]
  localparam logic [IDX_W-1:0] GLB_CTRL    = 5'd0;
  localparam logic [IDX_W-1:0] GLB_CEN_SET = 5'd2;
  localparam logic [IDX_W-1:0] GLB_CEN_CLR = 5'd3;
  localparam logic [IDX_W-1:0] GLB_IEN_SET = 5'd4;
  localparam logic [IDX_W-1:0] GLB_IEN_CLR = 5'd5;
  localparam logic [IDX_W-1:0] GLB_OVF     = 5'd8;
  // global control bits
  localparam int unsigned GBIT_RUN = 0;
  localparam int unsigned GBIT_ZAP = 1;
  localparam int unsigned CTL_W    = 8;
endpackage

// File: rtl/evt_w1_mask.sv
module evt_w1_mask #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] set_v, clr_v;

  assign set_v = set_stb ? bits : '0;
  assign clr_v = clr_stb ? bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_v) & ~clr_v;
  end
endmodule

// File: rtl/evt_ctr_lane.sv
module evt_ctr_lane #(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_EVT = 256,
  parameter int unsigned INC_W   = 4,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned CTL_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     zap,
  input  logic                     wr_cnt,
  input  logic                     wr_sel,
  input  logic                     wr_ctl,
  input  logic [CNT_W-1:0]         wd,
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  output logic [CNT_W-1:0]         cnt,
  output logic [SEL_W-1:0]         sel,
  output logic [CTL_W-1:0]         ctl,
  output logic                     wrap
);
  logic [INC_W-1:0] inc;
  logic [CNT_W:0]   sum;

  // event lane picked by this counter's selector
  assign inc  = evt_inc[sel*INC_W +: INC_W];
  assign sum  = {1'b0, cnt} + {{(CNT_W+1-INC_W){1'b0}}, inc};
  // carry-out only counts when the increment actually lands
  assign wrap = run & ~zap & ~wr_cnt & sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (zap)    cnt <= '0;
    else if (wr_cnt) cnt <= wd;
    else if (run)    cnt <= sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      ctl <= '0;
    end else begin
      if (wr_sel) sel <= wd[SEL_W-1:0];
      if (wr_ctl) ctl <= wd[CTL_W-1:0];
    end
  end
endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_EVT = 256,
  parameter int unsigned INC_W   = 4,
  parameter int unsigned DATA_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_AW-1:0]        addr,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  output logic                     irq
);
  localparam int unsigned SEL_W = $clog2(NUM_EVT);

  // address decode
  logic             aligned;
  logic [2:0]       rgn;
  logic [IDX_W-1:0] idx;
  logic             glb_hit;
  logic             wr_ctrl, wr_cen_set, wr_cen_clr, wr_ien_set, wr_ien_clr, wr_ovf;
  logic             zap;

  assign aligned    = (addr[2:0] == 3'b000);
  assign rgn        = addr[10:8];
  assign idx        = addr[7:3];
  assign glb_hit    = aligned && (rgn == RGN_GLB);
  assign wr_ctrl    = wr_en && glb_hit && (idx == GLB_CTRL);
  assign wr_cen_set = wr_en && glb_hit && (idx == GLB_CEN_SET);
  assign wr_cen_clr = wr_en && glb_hit && (idx == GLB_CEN_CLR);
  assign wr_ien_set = wr_en && glb_hit && (idx == GLB_IEN_SET);
  assign wr_ien_clr = wr_en && glb_hit && (idx == GLB_IEN_CLR);
  assign wr_ovf     = wr_en && glb_hit && (idx == GLB_OVF);
  assign zap        = wr_ctrl && wdata[GBIT_ZAP];

  // global state
  logic               gen_q;
  logic [NUM_CTR-1:0] cen_q, ien_q, ovf_q, wrap_vec;
  logic [NUM_CTR-1:0] wr_cnt, wr_sel, wr_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n)       gen_q <= 1'b0;
    else if (wr_ctrl) gen_q <= wdata[GBIT_RUN];
  end

  evt_w1_mask #(.W(NUM_CTR)) u_cen (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_cen_set), .clr_stb(wr_cen_clr),
    .bits(wdata[NUM_CTR-1:0]), .mask(cen_q)
  );

  evt_w1_mask #(.W(NUM_CTR)) u_ien (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_ien_set), .clr_stb(wr_ien_clr),
    .bits(wdata[NUM_CTR-1:0]), .mask(ien_q)
  );

  // overflow status: a fresh carry beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~(wr_ovf ? wdata[NUM_CTR-1:0] : '0)) | wrap_vec;
  end

  assign irq = |(ovf_q & ien_q);

  // counter lanes
  logic [CNT_W-1:0]         cnt_arr [NUM_CTR];
  logic [SEL_W-1:0]         sel_arr [NUM_CTR];
  logic [CTL_W-1:0]         ctl_arr [NUM_CTR];
  logic [NUM_CTR*CNT_W-1:0] cnt_flat;

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_lane
    assign wr_cnt[n] = wr_en && aligned && (rgn == RGN_CNT) && (idx == IDX_W'(n));
    assign wr_ctl[n] = wr_en && aligned && (rgn == RGN_CTL) && (idx == IDX_W'(n));
    assign wr_sel[n] = wr_en && aligned && (rgn == RGN_SEL) && (idx == IDX_W'(n));

    evt_ctr_lane #(
      .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .INC_W(INC_W), .SEL_W(SEL_W), .CTL_W(CTL_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .run(gen_q & cen_q[n]), .zap(zap),
      .wr_cnt(wr_cnt[n]), .wr_sel(wr_sel[n]), .wr_ctl(wr_ctl[n]),
      .wd(wdata[CNT_W-1:0]), .evt_inc(evt_inc),
      .cnt(cnt_arr[n]), .sel(sel_arr[n]), .ctl(ctl_arr[n]), .wrap(wrap_vec[n])
    );

    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_arr[n];
  end

  // read path, one register stage
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (aligned) begin
      case (rgn)
        RGN_CNT: for (int n = 0; n < NUM_CTR; n++) if (idx == IDX_W'(n)) rd_nxt = DATA_W'(cnt_arr[n]);
        RGN_CTL: for (int n = 0; n < NUM_CTR; n++) if (idx == IDX_W'(n)) rd_nxt = DATA_W'(ctl_arr[n]);
        RGN_SEL: for (int n = 0; n < NUM_CTR; n++) if (idx == IDX_W'(n)) rd_nxt = DATA_W'(sel_arr[n]);
        RGN_GLB: begin
          case (idx)
            GLB_CTRL:                 rd_nxt = DATA_W'(gen_q);
            GLB_CEN_SET, GLB_CEN_CLR: rd_nxt = DATA_W'(cen_q);
            GLB_IEN_SET, GLB_IEN_CLR: rd_nxt = DATA_W'(ien_q);
            GLB_OVF:                  rd_nxt = DATA_W'(ovf_q);
            default:                  rd_nxt = '0;
          endcase
        end
        default: rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_nxt;
  end
endmodule

// File: rtl/evt_counter_unit_chk.sv
module evt_counter_unit_chk #(
  parameter int unsigned NUM_CTR = 8,
  parameter int unsigned CNT_W   = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [7:0]               aword,
  input logic                     aligned,
  input logic                     wr_en,
  input logic [NUM_CTR-1:0]       wd_lo,
  input logic                     irq,
  input logic                     gen_q,
  input logic [NUM_CTR-1:0]       cen_q,
  input logic [NUM_CTR-1:0]       ien_q,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR*CNT_W-1:0] cnt_flat
);
  logic st_wr, ctrl_wr, cen_clr_wr, ien_set_wr, ien_clr_wr;

  assign st_wr      = wr_en && aligned && (aword == 8'h88);
  assign ctrl_wr    = wr_en && aligned && (aword == 8'h80);
  assign cen_clr_wr = wr_en && aligned && (aword == 8'h83);
  assign ien_set_wr = wr_en && aligned && (aword == 8'h84);
  assign ien_clr_wr = wr_en && aligned && (aword == 8'h85);

  // R6
  cen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cen_clr_wr |=> ((cen_q & $past(wd_lo)) == '0));

  // R7
  ien_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien_set_wr |=> ((ien_q & $past(wd_lo)) == $past(wd_lo)));

  // R10
  irq_mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_clr_wr && (&wd_lo)) |=> !irq);

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[n] && !(st_wr && wd_lo[n])) |=> ovf_q[n]);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_q && !(wr_en && aligned && (aword == 8'(n))) && !(ctrl_wr && wd_lo[1]))
        |=> $stable(cnt_flat[n*CNT_W +: CNT_W]));
  end
endmodule

bind evt_counter_unit evt_counter_unit_chk #(.NUM_CTR(NUM_CTR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .aword(addr[10:3]), .aligned(aligned), .wr_en(wr_en),
  .wd_lo(wdata[NUM_CTR-1:0]), .irq(irq), .gen_q(gen_q), .cen_q(cen_q),
  .ien_q(ien_q), .ovf_q(ovf_q), .cnt_flat(cnt_flat)
);

// File: tb/test_evt_counter_unit.sv
module test_evt_counter_unit;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [10:0]   addr = '0;
  logic          wr_en = 1'b0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [1023:0] evt_inc = '0;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  evt_counter_unit i_evt_counter_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .evt_inc(evt_inc), .irq(irq)
  );

  // reference model
  logic [63:0]   m_cnt [8];
  logic [7:0]    m_sel [8];
  logic [7:0]    m_ctl [8];
  logic          m_gen;
  logic [7:0]    m_cen, m_ien, m_ovf;
  logic [1023:0] ev;

  function automatic logic [63:0] model_read(input logic [10:0] a);
    if (a[2:0] != 3'b000) return 64'd0;
    if (a < 11'h040) return m_cnt[a[5:3]];
    if (a >= 11'h100 && a < 11'h140) return 64'(m_ctl[a[5:3]]);
    if (a >= 11'h200 && a < 11'h240) return 64'(m_sel[a[5:3]]);
    case (a)
      11'h400:          return 64'(m_gen);
      11'h410, 11'h418: return 64'(m_cen);
      11'h420, 11'h428: return 64'(m_ien);
      11'h440:          return 64'(m_ovf);
      default:          return 64'd0;
    endcase
  endfunction

  task automatic model_step(input logic [10:0] a, input logic we, input logic [63:0] wd);
    logic [7:0]  wrap = '0;
    logic        zap  = we && a == 11'h400 && wd[1];
    logic [64:0] s;
    for (int n = 0; n < 8; n++) begin
      s = {1'b0, m_cnt[n]} + 65'(ev[int'(m_sel[n])*4 +: 4]);
      if (zap) m_cnt[n] = '0;
      else if (we && a == 11'(8*n)) m_cnt[n] = wd;
      else if (m_gen && m_cen[n]) begin
        m_cnt[n] = s[63:0];
        wrap[n]  = s[64];
      end
    end
    if (we) begin
      for (int n = 0; n < 8; n++) begin
        if (a == 11'(12'h100 + 8*n)) m_ctl[n] = wd[7:0];
        if (a == 11'(12'h200 + 8*n)) m_sel[n] = wd[7:0];
      end
      case (a)
        11'h400: m_gen = wd[0];
        11'h410: m_cen = m_cen | wd[7:0];
        11'h418: m_cen = m_cen & ~wd[7:0];
        11'h420: m_ien = m_ien | wd[7:0];
        11'h428: m_ien = m_ien & ~wd[7:0];
        11'h440: m_ovf = m_ovf & ~wd[7:0];
        default: ;
      endcase
    end
    m_ovf = m_ovf | wrap;
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, compare at the following negedge
  task automatic cyc(input logic [10:0] a, input logic we, input logic [63:0] wd, input string tag);
    logic [63:0] exp_rd;
    addr = a; wr_en = we; wdata = wd; evt_inc = ev;
    exp_rd = model_read(a);
    model_step(a, we, wd);
    @(posedge clk);
    @(negedge clk);
    check(tag, rdata, exp_rd);
    check("R10 irq", 64'(irq), 64'(|(m_ovf & m_ien)));
    wr_en = 1'b0;
  endtask

  task automatic set_ev(input int lane, input logic [3:0] v);
    ev[lane*4 +: 4] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_sel[n] = '0; m_ctl[n] = '0; end
    m_gen = 1'b0; m_cen = '0; m_ien = '0; m_ovf = '0; ev = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cyc(11'h000, 0, 0, "R1 cnt0");
    cyc(11'h038, 0, 0, "R1 cnt7");
    cyc(11'h410, 0, 0, "R1 cen");
    cyc(11'h420, 0, 0, "R1 ien");
    cyc(11'h440, 0, 0, "R1 ovf");
    cyc(11'h400, 0, 0, "R1 ctrl");
    cyc(11'h208, 0, 0, "R1 sel1");

    // software init sequence, R6 R7 R5
    cyc(11'h418, 1, 64'hFF, "R6 init");
    cyc(11'h428, 1, 64'hFF, "R7 init");
    cyc(11'h440, 1, 64'hFF, "R8 init");
    cyc(11'h400, 1, 64'h2, "R5 init");

    // R3 selector and control field
    cyc(11'h200, 1, 64'd5, "R3 wsel0");
    cyc(11'h208, 1, 64'd200, "R3 wsel1");
    cyc(11'h110, 1, 64'hA5, "R3 wctl2");
    cyc(11'h200, 0, 0, "R3 sel0");
    cyc(11'h208, 0, 0, "R3 sel1");
    cyc(11'h110, 0, 0, "R3 ctl2");

    // R4 master run off: nothing moves
    set_ev(5, 4'd3); set_ev(200, 4'd2);
    cyc(11'h410, 1, 64'h03, "R6 cen set");
    cyc(11'h410, 0, 0, "R6 cen rd");
    repeat (3) cyc(11'h000, 0, 0, "R4 hold");
    cyc(11'h400, 1, 64'h1, "R4 run on");
    repeat (4) cyc(11'h000, 0, 0, "R3 count");
    cyc(11'h008, 0, 0, "R3 count1");

    // R6 zero bits leave others alone
    cyc(11'h418, 1, 64'h02, "R6 clr1");
    cyc(11'h418, 0, 0, "R6 mask");
    repeat (2) cyc(11'h008, 0, 0, "R6 held1");
    cyc(11'h410, 1, 64'h02, "R6 set1");

    // R2 write wins over increment
    cyc(11'h008, 1, 64'd100, "R2 wr");
    cyc(11'h008, 0, 0, "R2 rd");
    cyc(11'h008, 0, 0, "R2 inc");

    // R8 wrap sets status, R10 irq
    cyc(11'h000, 1, 64'hFFFF_FFFF_FFFF_FFFE, "R8 load");
    cyc(11'h440, 0, 0, "R8 wrap");
    cyc(11'h440, 0, 0, "R8 ovf");
    cyc(11'h420, 1, 64'h01, "R7 ien set");
    cyc(11'h428, 0, 0, "R7 ien rd");
    cyc(11'h440, 1, 64'h02, "R8 clr other");
    cyc(11'h440, 0, 0, "R8 kept");
    cyc(11'h440, 1, 64'h01, "R8 clr own");
    cyc(11'h440, 0, 0, "R10 drop");

    // R9 carry against clear in the same cycle
    cyc(11'h000, 1, 64'hFFFF_FFFF_FFFF_FFFE, "R9 load");
    cyc(11'h440, 1, 64'h01, "R9 collide");
    cyc(11'h440, 0, 0, "R9 stays");
    cyc(11'h428, 1, 64'hFF, "R10 mask all");

    // R11 unmapped and misaligned reads, writes ignored
    cyc(11'h300, 0, 0, "R11 hole");
    cyc(11'h448, 0, 0, "R11 past ovf");
    cyc(11'h040, 0, 0, "R11 ctr8");
    cyc(11'h404, 1, 64'h2, "R11 misaligned wr");
    cyc(11'h001, 0, 0, "R11 misaligned rd");
    cyc(11'h000, 0, 0, "R11 cnt intact");

    // R5 zap counters, status and run bit kept
    cyc(11'h400, 1, 64'h3, "R5 zap");
    cyc(11'h000, 0, 0, "R5 cnt0");
    cyc(11'h400, 0, 0, "R5 ctrl");
    cyc(11'h440, 0, 0, "R5 ovf");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [10:0] a;
      logic        we;
      logic [63:0] wd;
      int          k;
      for (int j = 0; j < 256; j++)
        ev[j*4 +: 4] = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0;
      k = $urandom_range(0, 7);
      we = 1'b1;
      wd = 64'($urandom_range(0, 255));
      case ($urandom_range(0, 11))
        0: begin a = 11'(8*k); wd = {56'hFF_FFFF_FFFF_FFFF, 8'($urandom)}; end
        1: a = 11'(12'h200 + 8*k);
        2: a = 11'h410;
        3: a = 11'h418;
        4: a = 11'h420;
        5: a = 11'h428;
        6: a = 11'h440;
        7: begin a = 11'h400; wd = {62'd0, $urandom_range(0, 15) == 0, $urandom_range(0, 5) != 0}; end
        default: begin we = 1'b0; a = 11'($urandom); if ($urandom_range(0, 1) == 0) a[10:6] = 5'd0; end
      endcase
      cyc(a, we, wd, "R2 R8 R9 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule